// File: doc/BRIEF.md
# Class-Aware Floating-Point Issue Interlock

This block sits beside the decode stage of an in-order pipeline whose floating-point execute section is four stages deep, followed by memory and writeback stages. Each cycle it sees at most one decoded instruction. That instruction carries a class code, a destination register and two source registers. The block holds the instruction in decode until every producer it reads from is far enough ahead. The required distance comes from a latency table indexed by the producer class and the consumer class, so the stall length is not a single fixed bubble.

Each register has a small countdown and a record of the class of its last producer. When an instruction leaves decode and writes a register, that register's countdown is loaded with the producer's deepest latency, and the countdown then falls by one each cycle. A consumer may leave decode once the remaining count is at or below the slack its class allows. All functional units are fully pipelined, so the block generates no structural stalls. It also does no forwarding, resolves no branches and handles no exceptions.

Class encoding on `id_cls`: 0 integer, 1 branch, 2 load, 3 store, 4 FP ALU. "Intervening cycles" means the number of cycles between the producer leaving decode and the consumer leaving decode, minus one.

Top module: `fpil_interlock`

## Requirements
- R1: After a synchronous reset, no producer is pending. An FP ALU instruction that reads any register leaves decode with zero stall cycles, even if a producer was in flight when reset was applied.
- R2: An FP ALU (class 4) result read by an FP ALU instruction needs 3 intervening cycles. Issued back to back, the consumer stalls exactly 3 cycles.
- R3: An FP ALU result read by a store (class 3) needs 2 intervening cycles. Issued back to back, the store stalls exactly 2 cycles.
- R4: A load (class 2) result read by an FP ALU instruction needs 1 intervening cycle, which gives 1 stall cycle back to back.
- R5: A load result read by a store needs 0 intervening cycles, so the store never stalls on it.
- R6: Register 0 is never recorded as a destination, and reading it as a source never stalls.
- R7: With `id_valid` low, `id_stall` is low, and the slot records no producer whatever its class and destination.
- R8: A stalled instruction becomes a producer only in the cycle it leaves decode. A consumer issued right behind it therefore sees the full latency, counted from that cycle.
- R9: Instructions that issue between a producer and its consumer count toward the latency. One independent instruction reduces an FP ALU to FP ALU stall from 3 to 2, and two independent instructions remove an FP ALU to store stall.
- R10: A newer producer of the same register replaces the older pending count and class. An integer (class 0) producer clears it, and an FP ALU producer that follows a load imposes its own latency.
- R11: Integer, branch and load consumers wait the producer's full latency (3 for FP ALU, 1 for load). Stores and branches record no destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | A decoded instruction is present |
| id_cls | input | 3 | Class code of the decoded instruction |
| id_dst | input | $clog2(NREGS) | Destination register |
| id_src1 | input | $clog2(NREGS) | First source register |
| id_src2 | input | $clog2(NREGS) | Second source register (store data for a store) |
| id_stall | output | 1 | Hold the instruction in decode this cycle |

## Verification
Two functions can fall in the same clock edge: a producer being written into a register's countdown, and the ordinary per-cycle decrement of that same countdown. This happens when an integer or FP ALU instruction overwrites a register whose earlier FP ALU or load result is still counting down. The bench issues such pairs back to back and then reads the register with a consumer. It judges the outcome by the stall count: zero when the newer producer is integer, and the newer producer's full latency when it is FP ALU. A second collision comes from releasing a stalled consumer in the same cycle that the next consumer reads its destination. That case is judged by the next consumer seeing the full three-cycle stall.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

  typedef enum logic [2:0] {
    CLS_INT = 3'd0,
    CLS_BR  = 3'd1,
    CLS_LD  = 3'd2,
    CLS_ST  = 3'd3,
    CLS_FPA = 3'd4
  } icls_e;

  function automatic logic cls_writes(icls_e c);
    return (c == CLS_INT) || (c == CLS_LD) || (c == CLS_FPA);
  endfunction

  function automatic int lat_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpil_lat_lookup.sv
// Slack a consumer class may accept from a producer class: the producer's
// preload depth minus the pair latency. Unlisted pairs get zero slack.
module fpil_lat_lookup
  import fpil_pkg::*;
#(
  parameter int LAT_FPA_FPA = 3,
  parameter int LAT_FPA_ST  = 2,
  parameter int LAT_LD_FPA  = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int CW          = 2
) (
  input  icls_e          prod_cls,
  input  icls_e          cons_cls,
  output logic [CW-1:0]  allow
);
  localparam int DEP_FPA = lat_max(LAT_FPA_FPA, LAT_FPA_ST);
  localparam int DEP_LD  = lat_max(LAT_LD_FPA, LAT_LD_ST);

  always_comb begin
    allow = '0;
    unique case (prod_cls)
      CLS_FPA: begin
        if (cons_cls == CLS_FPA)     allow = CW'(DEP_FPA - LAT_FPA_FPA);
        else if (cons_cls == CLS_ST) allow = CW'(DEP_FPA - LAT_FPA_ST);
      end
      CLS_LD: begin
        if (cons_cls == CLS_FPA)     allow = CW'(DEP_LD - LAT_LD_FPA);
        else if (cons_cls == CLS_ST) allow = CW'(DEP_LD - LAT_LD_ST);
      end
      default: allow = '0;
    endcase
  end
endmodule

// File: rtl/fpil_scoreboard.sv
// Per-register countdown and producer class. Every live entry decrements
// each cycle, so the state is kept in flops rather than a RAM.
module fpil_scoreboard
  import fpil_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  parameter int CW    = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_idx,
  input  logic [CW-1:0]            wr_depth,
  input  icls_e                    wr_cls,
  input  logic [NRD-1:0][AW-1:0]   rd_idx,
  output logic [NRD-1:0][CW-1:0]   rd_cnt,
  output icls_e                    rd_cls [NRD]
);
  logic [CW-1:0] cnt_q [NREGS];
  icls_e         cls_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    if (g == 0) begin : g_zero
      always_ff @(posedge clk) begin
        cnt_q[g] <= '0;
        cls_q[g] <= CLS_INT;
      end
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[g] <= '0;
          cls_q[g] <= CLS_INT;
        end else if (wr_en && wr_idx == AW'(g)) begin
          cnt_q[g] <= wr_depth;
          cls_q[g] <= wr_cls;
        end else if (cnt_q[g] != '0) begin
          cnt_q[g] <= cnt_q[g] - 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_cnt[r] = cnt_q[rd_idx[r]];
    assign rd_cls[r] = cls_q[rd_idx[r]];
  end
endmodule

// File: rtl/fpil_src_check.sv
// One source operand: blocks when its producer's remaining count exceeds
// the slack granted to the current consumer.
module fpil_src_check #(
  parameter int AW = 5,
  parameter int CW = 2
) (
  input  logic          valid,
  input  logic [AW-1:0] src_idx,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] allow,
  output logic          block
);
  assign block = valid && (src_idx != '0) && (cnt > allow);
endmodule

// File: rtl/fpil_interlock.sv
module fpil_interlock
  import fpil_pkg::*;
#(
  parameter int NREGS       = 32,
  parameter int LAT_FPA_FPA = 3,
  parameter int LAT_FPA_ST  = 2,
  parameter int LAT_LD_FPA  = 1,
  parameter int LAT_LD_ST   = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       id_valid,
  input  logic [2:0]                 id_cls,
  input  logic [$clog2(NREGS)-1:0]   id_dst,
  input  logic [$clog2(NREGS)-1:0]   id_src1,
  input  logic [$clog2(NREGS)-1:0]   id_src2,
  output logic                       id_stall
);
  localparam int AW      = $clog2(NREGS);
  localparam int NSRC    = 2;
  localparam int DEP_FPA = lat_max(LAT_FPA_FPA, LAT_FPA_ST);
  localparam int DEP_LD  = lat_max(LAT_LD_FPA, LAT_LD_ST);
  localparam int DEP_MAX = lat_max(lat_max(DEP_FPA, DEP_LD), 1);
  localparam int CW      = $clog2(DEP_MAX + 1);

  icls_e                    cls;
  logic                     issue;
  logic                     wr_en;
  logic [CW-1:0]            wr_depth;
  logic [NSRC-1:0][AW-1:0]  src_idx;
  logic [NSRC-1:0][CW-1:0]  src_cnt;
  icls_e                    src_cls [NSRC];
  logic [NSRC-1:0][CW-1:0]  src_allow;
  logic [NSRC-1:0]          src_block;

  assign cls        = icls_e'(id_cls);
  assign src_idx[0] = id_src1;
  assign src_idx[1] = id_src2;

  always_comb begin
    unique case (cls)
      CLS_FPA: wr_depth = CW'(DEP_FPA);
      CLS_LD:  wr_depth = CW'(DEP_LD);
      default: wr_depth = '0;
    endcase
  end

  assign id_stall = |src_block;
  assign issue    = id_valid && !id_stall;
  assign wr_en    = issue && cls_writes(cls) && (id_dst != '0);

  fpil_scoreboard #(
    .NREGS (NREGS),
    .NRD   (NSRC),
    .CW    (CW)
  ) u_sb (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (id_dst),
    .wr_depth (wr_depth),
    .wr_cls   (cls),
    .rd_idx   (src_idx),
    .rd_cnt   (src_cnt),
    .rd_cls   (src_cls)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    fpil_lat_lookup #(
      .LAT_FPA_FPA (LAT_FPA_FPA),
      .LAT_FPA_ST  (LAT_FPA_ST),
      .LAT_LD_FPA  (LAT_LD_FPA),
      .LAT_LD_ST   (LAT_LD_ST),
      .CW          (CW)
    ) u_lat (
      .prod_cls (src_cls[s]),
      .cons_cls (cls),
      .allow    (src_allow[s])
    );

    fpil_src_check #(
      .AW (AW),
      .CW (CW)
    ) u_chk (
      .valid   (id_valid),
      .src_idx (src_idx[s]),
      .cnt     (src_cnt[s]),
      .allow   (src_allow[s]),
      .block   (src_block[s])
    );
  end
endmodule

// File: rtl/fpil_interlock_chk.sv
module fpil_interlock_chk
  import fpil_pkg::*;
#(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          id_valid,
  input logic [2:0]    id_cls,
  input logic [AW-1:0] id_dst,
  input logic [AW-1:0] id_src1,
  input logic [AW-1:0] id_src2,
  input logic          id_stall
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> !id_stall);

  // R7
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !id_stall);

  // R6
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (id_src1 == '0 && id_src2 == '0) |-> !id_stall);

  // R2
  fpa_fpa_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && id_valid && !id_stall && id_cls == 3'(CLS_FPA) && id_dst != '0)
     && id_valid && id_cls == 3'(CLS_FPA) && id_src1 == $past(id_dst)) |-> id_stall);

  // R5
  ld_st_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && id_valid && !id_stall && id_cls == 3'(CLS_LD) && id_dst != '0)
     && id_valid && id_cls == 3'(CLS_ST)
     && id_src1 == $past(id_dst) && id_src2 == $past(id_dst)) |-> !id_stall);
endmodule

bind fpil_interlock fpil_interlock_chk #(.AW($clog2(NREGS))) u_fpil_chk (
  .clk      (clk),
  .rst      (rst),
  .id_valid (id_valid),
  .id_cls   (id_cls),
  .id_dst   (id_dst),
  .id_src1  (id_src1),
  .id_src2  (id_src2),
  .id_stall (id_stall)
);

// File: tb/fpil_interlock_bench.sv
module fpil_interlock_bench;
  import fpil_pkg::*;

  localparam int NREGS = 32;
  localparam int AW    = $clog2(NREGS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          id_valid = 1'b0;
  logic [2:0]    id_cls = '0;
  logic [AW-1:0] id_dst = '0;
  logic [AW-1:0] id_src1 = '0;
  logic [AW-1:0] id_src2 = '0;
  logic          id_stall;

  int checks = 0;
  int errors = 0;
  int n;

  always #2 clk = ~clk;

  fpil_interlock #(.NREGS(NREGS)) u_fpil_interlock (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_cls(id_cls),
    .id_dst(id_dst), .id_src1(id_src1), .id_src2(id_src2), .id_stall(id_stall)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instruction; return the number of cycles it was held.
  task automatic send(input icls_e c, input int d, input int s1, input int s2,
                      output int stalls);
    @(negedge clk);
    id_valid = 1'b1; id_cls = 3'(c);
    id_dst = AW'(d); id_src1 = AW'(s1); id_src2 = AW'(s2);
    #1;
    stalls = 0;
    while (id_stall && stalls < 20) begin
      stalls++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      id_valid = 1'b0; id_cls = '0; id_dst = '0; id_src1 = '0; id_src2 = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    id_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    int s;
    do_reset();
    #1 check("R1 stall after reset", int'(id_stall), 0);
    send(CLS_FPA, 1, 5, 6, s);
    check("R1 fresh reader", s, 0);
    send(CLS_FPA, 3, 0, 0, s);
    do_reset();
    send(CLS_FPA, 2, 3, 0, s);
    check("R1 reset drops pending", s, 0);
    idle(4);
  endtask

  task automatic t_pairs();
    int s;
    send(CLS_FPA, 1, 0, 0, s);
    send(CLS_FPA, 2, 1, 0, s);
    check("R2 fpalu->fpalu", s, 3);
    send(CLS_FPA, 3, 2, 0, s);
    check("R8 released consumer recorded on leave", s, 3);
    idle(4);
    send(CLS_FPA, 4, 0, 0, s);
    send(CLS_ST, 0, 0, 4, s);
    check("R3 fpalu->store", s, 2);
    idle(4);
    send(CLS_LD, 5, 0, 0, s);
    send(CLS_FPA, 9, 0, 5, s);
    check("R4 load->fpalu", s, 1);
    idle(4);
    send(CLS_LD, 6, 0, 0, s);
    send(CLS_ST, 0, 6, 6, s);
    check("R5 load->store", s, 0);
    idle(4);
  endtask

  task automatic t_gap();
    int s;
    send(CLS_FPA, 7, 0, 0, s);
    send(CLS_INT, 8, 0, 0, s);
    send(CLS_FPA, 10, 7, 0, s);
    check("R9 one gap fpalu->fpalu", s, 2);
    idle(4);
    send(CLS_FPA, 11, 0, 0, s);
    send(CLS_INT, 12, 0, 0, s);
    send(CLS_INT, 13, 0, 0, s);
    send(CLS_ST, 0, 0, 11, s);
    check("R9 two gaps fpalu->store", s, 0);
    idle(4);
  endtask

  task automatic t_reg0();
    int s;
    send(CLS_FPA, 0, 0, 0, s);
    send(CLS_FPA, 14, 0, 0, s);
    check("R6 register 0", s, 0);
    idle(4);
  endtask

  task automatic t_invalid();
    int s;
    send(CLS_FPA, 9, 0, 0, s);
    @(negedge clk);
    id_valid = 1'b0; id_cls = 3'(CLS_FPA); id_dst = AW'(10); id_src1 = AW'(9); id_src2 = AW'(9);
    #1 check("R7 idle slot stall", int'(id_stall), 0);
    send(CLS_FPA, 15, 10, 0, s);
    check("R7 idle slot not recorded", s, 0);
    idle(4);
  endtask

  task automatic t_waw();
    int s;
    send(CLS_FPA, 11, 0, 0, s);
    send(CLS_INT, 11, 0, 0, s);
    send(CLS_FPA, 16, 11, 0, s);
    check("R10 integer overwrite clears", s, 0);
    idle(4);
    send(CLS_LD, 12, 0, 0, s);
    send(CLS_FPA, 12, 0, 0, s);
    send(CLS_ST, 0, 0, 12, s);
    check("R10 fpalu overwrite of load", s, 2);
    idle(4);
  endtask

  task automatic t_other();
    int s;
    send(CLS_FPA, 13, 0, 0, s);
    send(CLS_INT, 17, 13, 0, s);
    check("R11 integer reads fpalu", s, 3);
    idle(4);
    send(CLS_LD, 14, 0, 0, s);
    send(CLS_BR, 0, 14, 0, s);
    check("R11 branch reads load", s, 1);
    idle(4);
    send(CLS_ST, 15, 0, 0, s);
    send(CLS_FPA, 18, 15, 0, s);
    check("R11 store records nothing", s, 0);
    idle(4);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_pairs();
    t_gap();
    t_reg0();
    t_invalid();
    t_waw();
    t_other();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule